// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block decides when an asynchronous DRAM controller must spend a cycle on refresh. After reset it holds everything off for a programmable start-up pause. It then asks for a fixed number of wake-up refresh cycles and only then reports the memory as ready for ordinary accesses. From that point a free-running interval timer adds one owed refresh per period to a saturating debt counter. Each completed refresh handshake pays one off. Once the debt reaches a programmable threshold, an urgency flag tells the access sequencer to stop favouring page hits.

The same block runs the self-refresh sleep sequence. A sleep request is taken only when nothing is owed. The block then asks for one refresh right before entry and pulses an entry strobe request. It keeps the strobe low for at least the self-refresh minimum. When the request drops, it pulses an exit strobe request, waits out the long self-refresh precharge, and asks for one refresh right after exit before it reports ready again. Sleep is only possible when the block is built for the low-power memory variant. Generating the strobes themselves belongs to the sequencer.

The refresh interface is a request/acknowledge pair that behaves like valid/ready. `ref_req` acts as valid and `ref_ack` as ready. A handshake occurs in any cycle where both are high. The sequencer may hold `ref_ack` low for as long as it likes, and the owed refreshes then pile up in the debt counter up to its ceiling. Once raised, `ref_req` does not drop before a handshake. `ref_ack` has no effect while `ref_req` is low. All time values are clock-cycle counts set by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ref_req`, `mem_ready`, `sr_enter` and `sr_exit` are low and `ref_urgent` is low for any nonzero threshold. After reset is released, `ref_req` stays low through the first PAUSE_CYC-1 clock edges and is first high after edge PAUSE_CYC.
- R2: After the pause, `ref_req` stays high until INIT_REFS handshakes have completed. `mem_ready` is low throughout and becomes high in the cycle after the final one.
- R3: A handshake is a cycle with `ref_req` and `ref_ack` both high. `ref_req` never falls without a handshake. `ref_ack` while `ref_req` is low changes nothing.
- R4: While ready, the debt rises by one every INTERVAL_CYC cycles, counted from the cycle ready rises, and falls by one per handshake. A tick and a handshake in the same cycle leave the debt unchanged. `ref_req` is high exactly when the debt is nonzero.
- R5: The debt saturates at 2^DEBT_W-1 and never wraps.
- R6: `ref_urgent` is high exactly when the debt is greater than or equal to `urgent_thr`.
- R7: A sleep request is accepted only in a cycle where `mem_ready` is high, `sleep_req` is high and the debt is zero. In the next cycle `mem_ready` drops and `ref_req` rises for the pre-entry refresh. `sr_enter` is a one-cycle pulse in the cycle after that handshake.
- R8: `sr_exit` is a one-cycle pulse at least SR_LOW_CYC+1 cycles after `sr_enter`. It comes exactly then if `sleep_req` is already low, otherwise in the cycle after `sleep_req` is seen low.
- R9: After `sr_exit`, `ref_req` and `mem_ready` stay low for SR_PRE_CYC cycles. `ref_req` then rises for the post-exit refresh, and `mem_ready` returns in the cycle after its handshake with the interval timer restarted from zero.
- R10: With LOW_POWER=0, `sleep_req` has no effect: `sr_enter` never pulses and `mem_ready` never falls once it has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| urgent_thr | input | DEBT_W | Debt level at which refresh turns urgent |
| ref_req | output | 1 | Refresh request (valid side of the handshake) |
| ref_ack | input | 1 | Sequencer accepts the refresh (ready side) |
| ref_urgent | output | 1 | Debt at or above threshold; preempt page hits |
| mem_ready | output | 1 | Memory may take normal accesses |
| sleep_req | input | 1 | Level: high asks for self-refresh, low asks to wake |
| sr_enter | output | 1 | One-cycle request to start the self-refresh strobe sequence |
| sr_exit | output | 1 | One-cycle request to end self-refresh (raise the row strobe) |

## Verification
The hardest state to reach is a full debt counter sitting on its ceiling while further interval ticks arrive. This only happens when the sequencer withholds acknowledges for many periods, so the bench stops acknowledging for ten intervals with the threshold at the ceiling and then checks that urgency is still set. The second hard case is a sleep request arriving while refreshes are still owed. The bench builds debt first, raises the sleep request without acknowledging, confirms that the block stays ready, and only then lets the debt drain so that entry can proceed. A cycle-level model in the bench follows every random mix of acknowledges, thresholds and sleep toggles, and a second instance built for the normal variant runs on the same stimulus.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [3:0] {
    ST_PAUSE = 4'd0,
    ST_INIT  = 4'd1,
    ST_RUN   = 4'd2,
    ST_PRE   = 4'd3,
    ST_ENTER = 4'd4,
    ST_HOLD  = 4'd5,
    ST_EXIT  = 4'd6,
    ST_PRECH = 4'd7,
    ST_POST  = 4'd8
  } drs_state_e;
endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/drs_debt.sv
module drs_debt #(
  parameter int DEBT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hs,
  output logic [DEBT_W-1:0] debt,
  output logic              debt_zero
);
  localparam logic [DEBT_W-1:0] CEIL = '1;

  logic pay;
  assign debt_zero = (debt == '0);
  assign pay       = hs && !debt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt <= '0;
    end else begin
      unique case ({tick, pay})
        2'b10:   if (debt != CEIL) debt <= debt + DEBT_W'(1);
        2'b01:   debt <= debt - DEBT_W'(1);
        default: debt <= debt;
      endcase
    end
  end
endmodule

// File: rtl/drs_ctl.sv
module drs_ctl
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC  = 50000,
  parameter int INIT_REFS  = 8,
  parameter int SR_LOW_CYC = 25000,
  parameter int SR_PRE_CYC = 28,
  parameter bit LOW_POWER  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  input  logic sleep_req,
  input  logic debt_zero,
  output logic ref_req,
  output logic hs,
  output logic run_en,
  output logic sr_enter,
  output logic sr_exit
);
  localparam int MAX_A   = (PAUSE_CYC > SR_LOW_CYC) ? PAUSE_CYC : SR_LOW_CYC;
  localparam int TMR_MAX = (MAX_A > SR_PRE_CYC) ? MAX_A : SR_PRE_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam int IW      = $clog2(INIT_REFS + 1);

  drs_state_e    st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] icnt;
  logic          sleep_ok;

  generate
    if (LOW_POWER) begin : g_lp
      assign sleep_ok = sleep_req;
    end else begin : g_np
      assign sleep_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (st)
      ST_INIT, ST_PRE, ST_POST: ref_req = 1'b1;
      ST_RUN:                   ref_req = !debt_zero;
      default:                  ref_req = 1'b0;
    endcase
  end

  assign hs       = ref_req && ref_ack;
  assign run_en   = (st == ST_RUN);
  assign sr_enter = (st == ST_ENTER);
  assign sr_exit  = (st == ST_EXIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_PAUSE;
      tmr  <= TW'(PAUSE_CYC - 1);
      icnt <= '0;
    end else begin
      unique case (st)
        ST_PAUSE: if (tmr == '0) st <= ST_INIT; else tmr <= tmr - TW'(1);
        ST_INIT: if (ref_ack) begin
          icnt <= icnt + IW'(1);
          if (icnt == IW'(INIT_REFS - 1)) st <= ST_RUN;
        end
        ST_RUN:   if (sleep_ok && debt_zero) st <= ST_PRE;
        ST_PRE:   if (ref_ack) st <= ST_ENTER;
        ST_ENTER: begin
          st  <= ST_HOLD;
          tmr <= TW'(SR_LOW_CYC - 1);
        end
        ST_HOLD: begin
          if (tmr != '0)      tmr <= tmr - TW'(1);
          else if (!sleep_ok) st  <= ST_EXIT;
        end
        ST_EXIT: begin
          st  <= ST_PRECH;
          tmr <= TW'(SR_PRE_CYC - 1);
        end
        ST_PRECH: if (tmr == '0) st <= ST_POST; else tmr <= tmr - TW'(1);
        ST_POST:  if (ref_ack) st <= ST_RUN;
        default:  st <= ST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC    = 50000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 3900,
  parameter int DEBT_W       = 4,
  parameter int SR_LOW_CYC   = 25000,
  parameter int SR_PRE_CYC   = 28,
  parameter bit LOW_POWER    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEBT_W-1:0] urgent_thr,
  output logic              ref_req,
  input  logic              ref_ack,
  output logic              ref_urgent,
  output logic              mem_ready,
  input  logic              sleep_req,
  output logic              sr_enter,
  output logic              sr_exit
);
  logic              tick, hs, run_en, debt_zero;
  logic [DEBT_W-1:0] debt;

  drs_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_iv (
    .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick)
  );

  drs_debt #(.DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hs(hs),
    .debt(debt), .debt_zero(debt_zero)
  );

  drs_ctl #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_REFS(INIT_REFS), .SR_LOW_CYC(SR_LOW_CYC),
    .SR_PRE_CYC(SR_PRE_CYC), .LOW_POWER(LOW_POWER)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .sleep_req(sleep_req),
    .debt_zero(debt_zero), .ref_req(ref_req), .hs(hs), .run_en(run_en),
    .sr_enter(sr_enter), .sr_exit(sr_exit)
  );

  assign mem_ready  = run_en;
  assign ref_urgent = (debt >= urgent_thr);
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int DEBT_W     = 4,
  parameter int SR_LOW_CYC = 25000,
  parameter bit LOW_POWER  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DEBT_W-1:0] urgent_thr,
  input logic              ref_req,
  input logic              ref_ack,
  input logic              ref_urgent,
  input logic              mem_ready,
  input logic              sr_enter,
  input logic              sr_exit
);
  localparam int CW = $clog2(SR_LOW_CYC + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (sr_enter)                   low_cnt <= '0;
    else if (low_cnt != CW'(SR_LOW_CYC)) low_cnt <= low_cnt + CW'(1);
  end

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  a_r2_ready_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(ref_req && ref_ack));

  a_r7_enter_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> $past(ref_req && ref_ack));

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter, sr_exit, mem_ready}));

  a_r8_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |-> (low_cnt >= CW'(SR_LOW_CYC)));

  a_r9_prech_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> (!ref_req && !mem_ready));

  a_r6_urgent_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && (urgent_thr != '0)) |-> ref_req);

  a_r10_no_sleep_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (LOW_POWER == 1'b0) |-> !sr_enter);
endmodule

bind dram_refresh_sched drs_checker #(
  .DEBT_W(DEBT_W), .SR_LOW_CYC(SR_LOW_CYC), .LOW_POWER(LOW_POWER)
) chk_i (.*);

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
  localparam int P_PAUSE = 40;
  localparam int P_INIT  = 8;
  localparam int P_INT   = 20;
  localparam int P_DW    = 3;
  localparam int P_LOW   = 30;
  localparam int P_PRE   = 4;
  localparam int P_MAX   = (1 << P_DW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, ref_ack, sleep_req;
  logic [P_DW-1:0] urgent_thr;
  logic ref_req, ref_urgent, mem_ready, sr_enter, sr_exit;
  logic np_req, np_urgent, np_ready, np_enter, np_exit;

  dram_refresh_sched #(.PAUSE_CYC(P_PAUSE), .INIT_REFS(P_INIT), .INTERVAL_CYC(P_INT),
    .DEBT_W(P_DW), .SR_LOW_CYC(P_LOW), .SR_PRE_CYC(P_PRE), .LOW_POWER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .urgent_thr(urgent_thr), .ref_req(ref_req),
    .ref_ack(ref_ack), .ref_urgent(ref_urgent), .mem_ready(mem_ready),
    .sleep_req(sleep_req), .sr_enter(sr_enter), .sr_exit(sr_exit));

  dram_refresh_sched #(.PAUSE_CYC(P_PAUSE), .INIT_REFS(P_INIT), .INTERVAL_CYC(P_INT),
    .DEBT_W(P_DW), .SR_LOW_CYC(P_LOW), .SR_PRE_CYC(P_PRE), .LOW_POWER(1'b0)) dut_np_i (
    .clk(clk), .rst_n(rst_n), .urgent_thr(urgent_thr), .ref_req(np_req),
    .ref_ack(ref_ack), .ref_urgent(np_urgent), .mem_ready(np_ready),
    .sleep_req(sleep_req), .sr_enter(np_enter), .sr_exit(np_exit));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Spec-level model. States: 0 pause,1 init,2 run,3 pre,4 enter,5 hold,6 exit,7 prech,8 post
  int m_st, m_tmr, m_ic, m_iv, m_debt;

  function automatic bit f_req(int st, int debt);
    if (st == 1 || st == 3 || st == 8) return 1'b1;
    if (st == 2) return (debt != 0);
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit req, hs, tk, dec;
    int od;
    if (!rst_n) begin
      m_st = 0; m_tmr = P_PAUSE - 1; m_ic = 0; m_iv = 0; m_debt = 0;
    end else begin
      od  = m_debt;
      req = f_req(m_st, od);
      hs  = req && ref_ack;
      tk  = (m_st == 2) && (m_iv == P_INT - 1);
      dec = hs && (od != 0);
      if (tk && !dec && od != P_MAX) m_debt = od + 1;
      else if (dec && !tk)           m_debt = od - 1;
      m_iv = (m_st == 2) ? (tk ? 0 : m_iv + 1) : 0;
      case (m_st)
        0: if (m_tmr == 0) m_st = 1; else m_tmr--;
        1: if (ref_ack) begin m_ic++; if (m_ic == P_INIT) m_st = 2; end
        2: if (sleep_req && od == 0) m_st = 3;
        3: if (ref_ack) m_st = 4;
        4: begin m_st = 5; m_tmr = P_LOW - 1; end
        5: if (m_tmr != 0) m_tmr--; else if (!sleep_req) m_st = 6;
        6: begin m_st = 7; m_tmr = P_PRE - 1; end
        7: if (m_tmr == 0) m_st = 8; else m_tmr--;
        8: if (ref_ack) m_st = 2;
        default: m_st = 0;
      endcase
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 ref_req", ref_req, f_req(m_st, m_debt));
      check("R2 mem_ready", mem_ready, m_st == 2);
      check("R6 ref_urgent", ref_urgent, m_debt >= int'(urgent_thr));
      check("R7 sr_enter", sr_enter, m_st == 4);
      check("R8 sr_exit", sr_exit, m_st == 6);
    end
  end

  // Normal-variant instance monitor (R10)
  bit np_entered = 1'b0, np_seen = 1'b0, np_dropped = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (np_enter) np_entered = 1'b1;
      if (np_seen && !np_ready) np_dropped = 1'b1;
      if (np_ready) np_seen = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual cycles=150000 expected completion earlier");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic drain();
    int n = 0;
    ref_ack = 1'b1;
    while (ref_req && n < 200) begin step(); n++; end
    ref_ack = 1'b0;
  endtask

  initial begin
    int n, acks;
    $urandom(1234);
    rst_n = 1'b0; ref_ack = 1'b0; sleep_req = 1'b0; urgent_thr = 3'd3;
    repeat (3) step();
    // R1 reset state
    check("R1 reset ref_req", ref_req, 0);
    check("R1 reset mem_ready", mem_ready, 0);
    check("R1 reset sr_enter", sr_enter, 0);
    check("R1 reset sr_exit", sr_exit, 0);
    check("R1 reset urgent", ref_urgent, 0);
    rst_n = 1'b1;
    // R1 pause length
    n = 0;
    do begin step(); n++; end while (!ref_req && n < 1000);
    check("R1 pause edges", n, P_PAUSE);
    // R2 initialization burst with random acknowledge gaps
    acks = 0;
    n = 0;
    while (!mem_ready && n < 1000) begin
      ref_ack = ($urandom % 3 == 0);
      if (ref_ack && ref_req) acks++;
      step();
      n++;
    end
    ref_ack = 1'b0;
    check("R2 handshakes before ready", acks, P_INIT);
    // R4 random normal operation
    for (int i = 0; i < 1500; i++) begin
      ref_ack = ($urandom % 4 == 0);
      if ($urandom % 50 == 0) urgent_thr = P_DW'($urandom % 8);
      step();
    end
    for (int i = 0; i < 1500; i++) begin
      ref_ack = ($urandom % 40 == 0);
      if ($urandom % 60 == 0) urgent_thr = P_DW'($urandom % 8);
      step();
    end
    // R3 ack while idle is ignored: one request cycle per tick
    drain();
    ref_ack = 1'b1;
    n = 0;
    for (int i = 0; i < 3 * P_INT; i++) begin
      step();
      if (ref_req) n++;
    end
    ref_ack = 1'b0;
    check("R3 request cycles with ack held", n, 3);
    // R5 saturation
    urgent_thr = P_DW'(P_MAX);
    repeat (10 * P_INT) step();
    check("R5 urgent at ceiling", ref_urgent, 1);
    check("R5 request pending", ref_req, 1);
    urgent_thr = 3'd2;
    drain();
    // R7 refused while debt owed
    repeat (2 * P_INT) step();
    sleep_req = 1'b1;
    repeat (5) step();
    check("R7 refused with debt", mem_ready, 1);
    drain();
    // now accepted (may already be in pre-entry refresh)
    n = 0;
    while (mem_ready && n < 100) begin step(); n++; end
    check("R7 pre-entry request", ref_req, 1);
    repeat (3) step();
    ref_ack = 1'b1;
    step();
    ref_ack = 1'b0;
    check("R7 sr_enter after handshake", sr_enter, 1);
    sleep_req = 1'b0;
    n = 0;
    do begin step(); n++; end while (!sr_exit && n < 1000);
    check("R8 exit distance", n, P_LOW + 1);
    n = 0;
    do begin step(); n++; end while (!ref_req && n < 1000);
    check("R9 precharge gap", n, P_PRE + 1);
    check("R9 not ready in post refresh", mem_ready, 0);
    ref_ack = 1'b1;
    step();
    ref_ack = 1'b0;
    check("R9 ready after post refresh", mem_ready, 1);
    // R8 held sleep: exit follows the drop
    sleep_req = 1'b1;
    n = 0;
    ref_ack = 1'b1;
    while (!sr_enter && n < 200) begin step(); n++; end
    ref_ack = 1'b0;
    repeat (P_LOW + 40) step();
    check("R8 still asleep while held", sr_exit, 0);
    sleep_req = 1'b0;
    step();
    check("R8 exit after drop", sr_exit, 1);
    repeat (P_PRE + 2) step();
    drain();
    // random mix with sleep toggles
    for (int i = 0; i < 4000; i++) begin
      ref_ack = ($urandom % 3 == 0);
      if ($urandom % 120 == 0) sleep_req = ~sleep_req;
      if ($urandom % 80 == 0) urgent_thr = P_DW'($urandom % 8);
      step();
    end
    sleep_req = 1'b0;
    ref_ack = 1'b1;
    repeat (P_LOW + P_PRE + 20) step();
    ref_ack = 1'b0;
    step();
    // R10 normal variant ignores sleep
    check("R10 no sr_enter on normal variant", np_entered, 0);
    check("R10 ready never fell on normal variant", np_dropped, 0);
    check("R10 normal variant reached ready", np_seen, 1);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule